// File: doc/BRIEF.md
# Windowed Pulse Speed Meter

This block measures the rate of a pulse train by counting its rising edges over a repeating time window. The window length is given in milliseconds, and a 1 kHz tick input paces the window. Three values are visible at all times. The first is the live count of edges in the window now running. The second is the final count of the window that last closed. The third is the number of milliseconds left before the current window closes.

The pulse input must already be synchronised to the clock and free of bounce. Turning the count into speed units is left to the consumer of `last_count`.

Control is a two-state machine. **IDLE** holds the live count and the remaining time at zero. **RUN** counts edges and steps the window timer down. The transition **START** (IDLE to RUN, taken when enable is high) loads the window length. The self-loop **ROLL** (RUN to RUN, taken on the tick that closes a window) latches the count and reloads the timer. The transition **STOP** (RUN to IDLE, taken when enable is low) clears the live values.

Top module: `psm_speed_meter`

## Requirements
- R1: Each 0-to-1 transition of `pulse_in` seen during RUN adds one to `live_count`. A level held high adds only once.
- R2: On the tick that takes `remain_ms` from 1 to its end, `window_done` is high for exactly one cycle after that clock edge. In that same cycle `last_count` holds the live count from just before the edge.
- R3: On the window-closing tick, `live_count` restarts and `remain_ms` reloads to the window length. Both happen on the same edge.
- R4: A rising edge on the same cycle as the window-closing tick belongs to the new window, so `live_count` is then 1.
- R5: `live_count` saturates at 0xFFFF and does not wrap.
- R6: While `enable` is low, `live_count` and `remain_ms` are zero and ticks have no effect. `last_count` keeps its value.
- R7: A `window_ms` of 0 acts as a 1 ms window, so every tick closes a window.
- R8: In RUN, each tick lowers `remain_ms` by one. On the first enabled cycle (START), `remain_ms` loads the window length.
- R9: After reset, all three counts are zero and `window_done` is low.
- R10: A change of `window_ms` during a window takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the meter when high |
| pulse_in | input | 1 | Synchronised pulse train |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| window_ms | input | 16 | Window length in ms (0 treated as 1) |
| live_count | output | 16 | Edges counted in the current window |
| last_count | output | 16 | Final count of the previous window |
| remain_ms | output | 16 | Milliseconds left in the current window |
| window_done | output | 1 | One-cycle strobe after a window closes |

## Verification
The checker tests several rules on every cycle:
- The latch handover on `window_done`, and the reload value that follows it.
- The one-per-tick decrement of the timer.
- Saturation hold at the top of the count.
- Zeroed live values while disabled.
- That `last_count` never moves outside a window close.

Some behaviours only the bench scenarios can show. These are the exact count that a given edge pattern produces, the cycle in which a window closes for a given length, and the zero-length case. They also include an edge that lands on the closing tick, and a window length changed mid-window.

// File: rtl/psm_pkg.sv
package psm_pkg;
    localparam int CNT_W = 16;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } psm_state_e;
endpackage

// File: rtl/psm_edge_detect.sv
module psm_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/psm_window_timer.sv
module psm_window_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] remain,
    output logic         at_last
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     remain_q <= '0;
        else if (clear) remain_q <= '0;
        else if (load)  remain_q <= load_val;
        else if (step)  remain_q <= remain_q - ONE;
    end

    assign remain  = remain_q;
    assign at_last = (remain_q == ONE);
endmodule

// File: rtl/psm_speed_meter.sv
module psm_speed_meter
    import psm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         pulse_in,
    input  logic         tick_ms,
    input  logic [W-1:0] window_ms,
    output logic [W-1:0] live_count,
    output logic [W-1:0] last_count,
    output logic [W-1:0] remain_ms,
    output logic         window_done
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    psm_state_e state_q, state_d;
    logic         rise;
    logic         at_last;
    logic         win_end;
    logic         tmr_load, tmr_clear, tmr_step;
    logic [W-1:0] eff_window;
    logic [W-1:0] live_q, last_q;
    logic         done_q;

    psm_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (pulse_in),
        .rise   (rise)
    );

    assign eff_window = (window_ms == '0) ? ONE : window_ms;

    psm_window_timer #(.W(W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .load     (tmr_load),
        .step     (tmr_step),
        .load_val (eff_window),
        .remain   (remain_ms),
        .at_last  (at_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and timer control
    always_comb begin
        state_d   = state_q;
        win_end   = 1'b0;
        tmr_load  = 1'b0;
        tmr_clear = !enable;
        tmr_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_d  = ST_RUN;
                    tmr_load = 1'b1;
                end
            end
            ST_RUN: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (tick_ms) begin
                    win_end  = at_last;
                    tmr_load = at_last;
                    tmr_step = !at_last;
                end
            end
        endcase
    end

    // Outputs: counts and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            last_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: live_q <= '0;
                ST_RUN: begin
                    if (!enable) begin
                        live_q <= '0;
                    end else if (win_end) begin
                        last_q <= live_q;
                        done_q <= 1'b1;
                        live_q <= rise ? ONE : '0;
                    end else if (rise && live_q != CNT_MAX) begin
                        live_q <= live_q + ONE;
                    end
                end
            endcase
        end
    end

    assign live_count  = live_q;
    assign last_count  = last_q;
    assign window_done = done_q;
endmodule

// File: rtl/psm_speed_meter_chk.sv
module psm_speed_meter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         tick_ms,
    input logic [W-1:0] window_ms,
    input logic [W-1:0] live_count,
    input logic [W-1:0] last_count,
    input logic [W-1:0] remain_ms,
    input logic         window_done
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    // R2
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |-> last_count == $past(live_count));

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |-> remain_ms == (($past(window_ms) == '0) ? ONE : $past(window_ms)));

    // R2
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !window_done |-> $stable(last_count));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_count == CNT_MAX && enable && !(tick_ms && remain_ms == ONE)) |=> live_count == CNT_MAX);

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick_ms && remain_ms > ONE) |=> remain_ms == $past(remain_ms) - ONE);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (live_count == '0 && remain_ms == '0 && !window_done));
endmodule

bind psm_speed_meter psm_speed_meter_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .tick_ms     (tick_ms),
    .window_ms   (window_ms),
    .live_count  (live_count),
    .last_count  (last_count),
    .remain_ms   (remain_ms),
    .window_done (window_done)
);

// File: tb/psm_speed_meter_test.sv
module psm_speed_meter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        pulse_in = 1'b0;
    logic        tick_ms = 1'b0;
    logic [15:0] window_ms = '0;
    logic [15:0] live_count, last_count, remain_ms;
    logic        window_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    psm_speed_meter uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pulse_in(pulse_in),
        .tick_ms(tick_ms), .window_ms(window_ms), .live_count(live_count),
        .last_count(last_count), .remain_ms(remain_ms), .window_done(window_done)
    );

    // {window length, edge count}
    localparam logic [31:0] VEC [5] = '{
        {16'd0, 16'd0}, {16'd1, 16'd3}, {16'd4, 16'd2},
        {16'd7, 16'd5}, {16'd2, 16'd1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic edge_once();
        pulse_in = 1'b1; cyc();
        pulse_in = 1'b0; cyc();
    endtask

    task automatic tick_once();
        tick_ms = 1'b1; cyc();
        tick_ms = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] w, e, eff;
        repeat (3) cyc();
        // R9 reset state
        check("R9 live", live_count, 0);
        check("R9 last", last_count, 0);
        check("R9 remain", remain_ms, 0);
        check("R9 done", {15'd0, window_done}, 0);
        rst_n = 1'b1; cyc();

        for (int i = 0; i < 5; i++) begin
            w = VEC[i][31:16]; e = VEC[i][15:0];
            eff = (w == 0) ? 16'd1 : w;
            window_ms = w; enable = 1'b1; cyc();
            check("R8 load", remain_ms, eff);
            for (int k = 0; k < int'(e); k++) edge_once();
            check("R1 count", live_count, e);
            for (int k = 1; k < int'(eff); k++) tick_once();
            check("R8 step", remain_ms, 16'd1);
            tick_once();
            check("R2 done", {15'd0, window_done}, 1);
            check("R2 last", last_count, e);
            check("R3 restart", live_count, 0);
            check(w == 0 ? "R7 reload" : "R3 reload", remain_ms, eff);
            cyc();
            check("R2 one cycle", {15'd0, window_done}, 0);
            enable = 1'b0; cyc();
            check("R6 live", live_count, 0);
            check("R6 remain", remain_ms, 0);
            check("R6 last kept", last_count, e);
        end

        // R6 tick while disabled
        tick_once();
        check("R6 tick idle", remain_ms, 0);
        check("R6 tick idle done", {15'd0, window_done}, 0);

        // R1 level held high counts once
        window_ms = 16'd50; enable = 1'b1; cyc();
        pulse_in = 1'b1; repeat (5) cyc(); pulse_in = 1'b0; cyc();
        check("R1 held level", live_count, 1);
        enable = 1'b0; cyc();

        // R4 edge on closing tick
        window_ms = 16'd2; enable = 1'b1; cyc();
        tick_once();
        pulse_in = 1'b1; tick_ms = 1'b1; cyc();
        pulse_in = 1'b0; tick_ms = 1'b0;
        check("R4 new window", live_count, 1);
        check("R4 old window", last_count, 0);
        enable = 1'b0; cyc();

        // R10 change length mid-window
        window_ms = 16'd3; enable = 1'b1; cyc();
        window_ms = 16'd5;
        tick_once(); tick_once();
        check("R10 old length", remain_ms, 1);
        tick_once();
        check("R10 done", {15'd0, window_done}, 1);
        check("R10 new length", remain_ms, 5);
        enable = 1'b0; cyc();

        // R5 saturation
        window_ms = 16'd1000; enable = 1'b1; cyc();
        for (int k = 0; k < 65540; k++) begin
            pulse_in = 1'b1; cyc();
            pulse_in = 1'b0; cyc();
        end
        check("R5 saturate", live_count, 16'hFFFF);
        check("R5 no tick", remain_ms, 1000);
        enable = 1'b0; cyc();
        check("R6 after sat", live_count, 0);

        finish_run();
    end
endmodule